// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM read or write burst. When the parent asserts `start`, the block captures a starting column, a burst-length code and an ordering select. These settings come from the decoded mode register. The block then shows the first column of the burst on the next cycle. Each cycle in which `adv` is high moves the block to the next beat. A flag marks the final beat of the burst.

Fixed-length bursts keep the column inside the aligned block of the burst length. Sequential order adds the beat index and wraps inside that block. Interleaved order XORs the beat index into the low bits. A full-page burst counts upward through every column, wrapping at the top of the column space. It runs until it is terminated. A terminate input ends any burst, whether it comes from a burst-stop or a precharge command. A fresh `start` during a burst drops the old burst and begins the new one, which covers back-to-back read or write commands.

Top module: `sdram_burst_colgen`

## Requirements
- R1: During and straight after reset, `active` and `last` are 0 and `col_out` is 0.
- R2: The length codes are: 3'b000 one beat, 3'b001 two, 3'b010 four, 3'b011 eight, and 3'b111 full page. `ilv`=0 selects sequential order and `ilv`=1 selects interleaved order. A `start` with a legal setting makes `active` 1 on the next cycle, with `col_out` equal to the captured `start_col`.
- R3: In sequential order, beat k of an N-beat burst has low log2(N) bits equal to (start + k) mod N.
- R4: In interleaved order, beat k has low log2(N) bits equal to start XOR k.
- R5: Column bits above the low log2(N) bits keep their starting values for the whole burst.
- R6: `last` is 1 only on the final beat of a fixed-length burst. An `adv` on that beat ends the burst, so `active` reads 0 on the next cycle.
- R7: For a one-beat burst, `last` is already 1 on the first cycle the column is shown.
- R8: A full-page burst increments the column modulo 2^COL_W on every `adv` and never asserts `last`.
- R9: `term` ends the burst on the next cycle. When `start` and `term` arrive together, `start` wins.
- R10: A legal `start` during a burst restarts at the new column, with the new length and order.
- R11: A `start` with a reserved length code (3'b100, 3'b101, 3'b110), or with full page together with interleaved order, is ignored. An idle block stays idle, and a running burst goes on unchanged.
- R12: While `adv` is 0, the column and `last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a new burst |
| start_col | input | COL_W | Starting column |
| bl_code | input | 3 | Burst-length code |
| ilv | input | 1 | 0 sequential, 1 interleaved |
| adv | input | 1 | Advance one beat |
| term | input | 1 | End the burst |
| col_out | output | COL_W | Column of the current beat |
| active | output | 1 | A burst is in progress |
| last | output | 1 | Current beat is the final one |

## Verification
The bench uses start columns that sit near the top of an aligned block. If the design propagated a carry out of the low field, the column would move into the next block. If it used an add in place of an XOR, the interleaved vectors would come out in counting order. A full-page run starts two columns below the top and goes once around the column space. This catches a design that stops at a block edge or raises `last`. Directed cases cover the following:
- a terminate and a start in the same cycle;
- a restart in mid-burst;
- a held `adv`;
- reserved codes while idle and while busy.

A design that lets a reserved code through would show a spurious burst, or it would corrupt the running one.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      BL_ONE   = 3'b000,
      BL_TWO   = 3'b001,
      BL_FOUR  = 3'b010,
      BL_EIGHT = 3'b011,
      BL_PAGE  = 3'b111
   } bl_code_e;

   localparam logic ORD_SEQ = 1'b0;
   localparam logic ORD_ILV = 1'b1;
endpackage

// File: rtl/colgen_decode.sv
module colgen_decode #(
   parameter int COL_W   = 10,
   parameter int MAX_LOG = 3,
   parameter bit PAGE_EN = 1'b1,
   parameter bit ILV_EN  = 1'b1
) (
   input  logic [colgen_pkg::CODE_W-1:0] code,
   input  logic                          ilv,
   output logic                          ok,
   output logic                          page,
   output logic [COL_W-1:0]              mask
);
   localparam logic [COL_W-1:0] ONE    = COL_W'(1);
   localparam logic [3:0]       LEN_OK = 4'b1111 >> (3 - MAX_LOG);

   logic ord_ok;

   generate
      if (ILV_EN) begin : g_ord_any
         assign ord_ok = 1'b1;
      end else begin : g_ord_seq
         assign ord_ok = (ilv == colgen_pkg::ORD_SEQ);
      end
   endgenerate

   always_comb begin
      ok   = 1'b0;
      page = 1'b0;
      mask = '0;
      case (code)
         colgen_pkg::BL_PAGE: begin
            page = 1'b1;
            mask = '1;
            ok   = PAGE_EN && (ilv == colgen_pkg::ORD_SEQ);
         end
         colgen_pkg::BL_ONE, colgen_pkg::BL_TWO,
         colgen_pkg::BL_FOUR, colgen_pkg::BL_EIGHT: begin
            mask = (ONE << code[1:0]) - ONE;
            ok   = LEN_OK[code[1:0]];
         end
         default: ;
      endcase
      ok = ok && ord_ok;
   end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl #(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             page_in,
   input  logic             adv,
   input  logic             term,
   input  logic [COL_W-1:0] mask_q,
   output logic [COL_W-1:0] idx,
   output logic             active,
   output logic             page_q,
   output logic             last
);
   assign last = active && !page_q && (idx == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= '0;
         active <= 1'b0;
         page_q <= 1'b0;
      end else if (load) begin
         idx    <= '0;
         active <= 1'b1;
         page_q <= page_in;
      end else if (term) begin
         active <= 1'b0;
      end else if (active && adv) begin
         if (last) begin
            active <= 1'b0;
         end else begin
            idx <= idx + COL_W'(1);
         end
      end
   end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
   parameter int COL_W  = 10,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [COL_W-1:0] base_in,
   input  logic [COL_W-1:0] mask_in,
   input  logic             ilv_in,
   input  logic [COL_W-1:0] idx,
   output logic [COL_W-1:0] mask_q,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
      end else if (load) begin
         base_q <= base_in;
         mask_q <= mask_in;
      end
   end

   generate
      if (ILV_EN) begin : g_ilv
         logic ilv_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    ilv_q <= 1'b0;
            else if (load) ilv_q <= ilv_in;
         end
         assign merged = ilv_q ? (base_q ^ idx) : (base_q + idx);
      end else begin : g_seq
         logic ilv_unused;
         assign ilv_unused = ilv_in;
         assign merged     = base_q + idx;
      end
   endgenerate

   assign col = (base_q & ~mask_q) | (merged & mask_q);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
   parameter int COL_W   = 10,
   parameter int MAX_LOG = 3,
   parameter bit PAGE_EN = 1'b1,
   parameter bit ILV_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       bl_code,
   input  logic             ilv,
   input  logic             adv,
   input  logic             term,
   output logic [COL_W-1:0] col_out,
   output logic             active,
   output logic             last
);
   generate
      if (MAX_LOG < 0 || MAX_LOG > 3) begin : g_bad_log
         $error("MAX_LOG must lie in 0..3");
      end
      if (COL_W <= MAX_LOG) begin : g_bad_width
         $error("COL_W must exceed MAX_LOG");
      end
   endgenerate

   logic             dec_ok;
   logic             dec_page;
   logic [COL_W-1:0] dec_mask;
   logic             start_ok;
   logic [COL_W-1:0] idx;
   logic [COL_W-1:0] mask_q;
   logic             page_q;

   colgen_decode #(
      .COL_W(COL_W), .MAX_LOG(MAX_LOG), .PAGE_EN(PAGE_EN), .ILV_EN(ILV_EN)
   ) u_decode (
      .code(bl_code), .ilv(ilv), .ok(dec_ok), .page(dec_page), .mask(dec_mask)
   );

   assign start_ok = start && dec_ok;

   colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .page_in(dec_page),
      .adv(adv), .term(term), .mask_q(mask_q), .idx(idx),
      .active(active), .page_q(page_q), .last(last)
   );

   colgen_addr #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .base_in(start_col),
      .mask_in(dec_mask), .ilv_in(ilv), .idx(idx), .mask_q(mask_q),
      .col(col_out)
   );
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic [2:0]       bl_code,
   input logic             adv,
   input logic             term,
   input logic [COL_W-1:0] col_out,
   input logic             active,
   input logic             last,
   input logic [COL_W-1:0] mask_q,
   input logic             page_q,
   input logic             start_ok
);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> active && (col_out == $past(start_col)));

   p_high_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active && !start_ok |=> ((col_out & ~mask_q) == ($past(col_out) & ~mask_q)));

   p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> active);

   p_end_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last && adv && !start_ok |=> !active);

   p_one_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok && (bl_code == 3'b000) |=> last);

   p_page_no_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      active && page_q |-> !last);

   p_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
      term && !start_ok |=> !active);

   p_ignore_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start && !start_ok && !active |=> !active);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      active && !adv && !start && !term |=> $stable(col_out) && $stable(last));
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
   .bl_code(bl_code), .adv(adv), .term(term), .col_out(col_out),
   .active(active), .last(last), .mask_q(mask_q), .page_q(page_q),
   .start_ok(start_ok)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
   localparam int COL_W = 10;
   localparam int NV    = 8;

   localparam logic [9:0] VCOL  [NV] = '{10'h005, 10'h005, 10'h2B7, 10'h2B7,
                                         10'h3FE, 10'h3FE, 10'h155, 10'h100};
   localparam logic [2:0] VCODE [NV] = '{3'b011, 3'b011, 3'b010, 3'b010,
                                         3'b011, 3'b011, 3'b001, 3'b000};
   localparam logic       VORD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                         1'b0, 1'b1, 1'b0, 1'b0};
   localparam logic [9:0] VEXP  [NV][8] = '{
      '{10'h005, 10'h006, 10'h007, 10'h000, 10'h001, 10'h002, 10'h003, 10'h004},
      '{10'h005, 10'h004, 10'h007, 10'h006, 10'h001, 10'h000, 10'h003, 10'h002},
      '{10'h2B7, 10'h2B4, 10'h2B5, 10'h2B6, 10'h000, 10'h000, 10'h000, 10'h000},
      '{10'h2B7, 10'h2B6, 10'h2B5, 10'h2B4, 10'h000, 10'h000, 10'h000, 10'h000},
      '{10'h3FE, 10'h3FF, 10'h3F8, 10'h3F9, 10'h3FA, 10'h3FB, 10'h3FC, 10'h3FD},
      '{10'h3FE, 10'h3FF, 10'h3FC, 10'h3FD, 10'h3FA, 10'h3FB, 10'h3F8, 10'h3F9},
      '{10'h155, 10'h154, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000},
      '{10'h100, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000}};

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start;
   logic [COL_W-1:0] start_col;
   logic [2:0]       bl_code;
   logic             ilv;
   logic             adv;
   logic             term;
   logic [COL_W-1:0] col_out;
   logic             active;
   logic             last;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .bl_code(bl_code), .ilv(ilv), .adv(adv), .term(term),
      .col_out(col_out), .active(active), .last(last)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_col(input string req, input logic [COL_W-1:0] exp);
      chk(col_out == exp, req, "col_out", int'(col_out), int'(exp));
   endtask

   task automatic chk_bit(input string req, input string what,
                          input logic act, input logic exp);
      chk(act == exp, req, what, int'(act), int'(exp));
   endtask

   task automatic launch(input logic [COL_W-1:0] c, input logic [2:0] code,
                         input logic o);
      start = 1'b1; start_col = c; bl_code = code; ilv = o;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; start_col = '0; bl_code = '0;
      ilv = 1'b0; adv = 1'b0; term = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_bit("R1", "active", active, 1'b0);
      chk_bit("R1", "last", last, 1'b0);
      chk_col("R1", '0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table of bursts: R2 load, R3/R4 order, R5 upper bits, R6 last, R7 one beat
      for (int v = 0; v < NV; v++) begin
         int nb;
         nb = 1 << VCODE[v];
         launch(VCOL[v], VCODE[v], VORD[v]);
         chk_bit("R2", "active", active, 1'b1);
         for (int k = 0; k < nb; k++) begin
            chk_col(VORD[v] ? "R4 R5" : "R3 R5", VEXP[v][k]);
            chk_bit(nb == 1 ? "R7" : "R6", "last", last, logic'(k == nb - 1));
            adv = 1'b1;
            @(negedge clk);
         end
         adv = 1'b0;
         chk_bit("R6", "active after final beat", active, 1'b0);
      end

      // R12: hold while adv is low
      launch(10'h010, 3'b010, 1'b0);
      repeat (2) @(negedge clk);
      chk_col("R12", 10'h010);
      chk_bit("R12", "last", last, 1'b0);
      adv = 1'b1; @(negedge clk); adv = 1'b0;
      chk_col("R12", 10'h011);

      // R9: terminate mid-burst
      term = 1'b1; @(negedge clk); term = 1'b0;
      chk_bit("R9", "active", active, 1'b0);
      chk_bit("R9", "last", last, 1'b0);

      // R9: start wins over term
      launch(10'h040, 3'b001, 1'b0);
      start = 1'b1; term = 1'b1; start_col = 10'h081; bl_code = 3'b001;
      @(negedge clk);
      start = 1'b0; term = 1'b0;
      chk_bit("R9", "active with start+term", active, 1'b1);
      chk_col("R9", 10'h081);

      // R10: restart in mid-burst with a new length and order
      launch(10'h005, 3'b011, 1'b0);
      adv = 1'b1; repeat (2) @(negedge clk); adv = 1'b0;
      chk_col("R10", 10'h007);
      launch(10'h023, 3'b001, 1'b1);
      chk_col("R10", 10'h023);
      chk_bit("R10", "last", last, 1'b0);
      adv = 1'b1; @(negedge clk);
      chk_col("R10", 10'h022);
      chk_bit("R10", "last", last, 1'b1);
      @(negedge clk); adv = 1'b0;
      chk_bit("R10", "active", active, 1'b0);

      // R11: reserved codes ignored while idle
      launch(10'h001, 3'b100, 1'b0);
      chk_bit("R11", "active code 100", active, 1'b0);
      launch(10'h001, 3'b110, 1'b0);
      chk_bit("R11", "active code 110", active, 1'b0);
      launch(10'h001, 3'b111, 1'b1);
      chk_bit("R11", "active page+interleave", active, 1'b0);

      // R11: reserved start while busy leaves the burst running
      launch(10'h0C1, 3'b010, 1'b1);
      launch(10'h3FF, 3'b101, 1'b0);
      chk_bit("R11", "active busy", active, 1'b1);
      chk_col("R11", 10'h0C1);
      adv = 1'b1; @(negedge clk); adv = 1'b0;
      chk_col("R11", 10'h0C0);
      term = 1'b1; @(negedge clk); term = 1'b0;

      // R8: full page from two below the top, once around the column space
      launch(10'h3FE, 3'b111, 1'b0);
      chk_col("R8", 10'h3FE);
      adv = 1'b1;
      for (int k = 1; k <= 1024; k++) begin
         @(negedge clk);
         chk_col("R8", COL_W'(10'h3FE + k));
         chk_bit("R8", "last", last, 1'b0);
      end
      adv = 1'b0;
      chk_bit("R8", "active", active, 1'b1);
      term = 1'b1; @(negedge clk); term = 1'b0;
      chk_bit("R8", "active after term", active, 1'b0);

      summary();
      $finish;
   end
endmodule